// File: doc/BRIEF.md
# HDLC Transmit Pool Controller

This block sits between a processor and an HDLC bit-level transmitter and holds outgoing frame bytes in two alternating banks of 32 bytes each. The processor fills the bank it can reach through a byte write port, then issues a send command to hand that bank to the transmit side. Meanwhile the other bank is streamed to the framer as a ready/valid byte stream. The block reports each hand-off of a bank back to the processor through sticky status flags and one maskable interrupt line.

A frame may run across many banks. A send command without the end-of-message qualifier keeps the frame open, and the block asks for the next bank when one drains. A command with the qualifier closes the frame, so the last byte of that bank carries an end-of-frame mark. If the framer wants a byte while the frame is still open and no bank is queued, the block sends an abort marker in place of data and flags an underrun. A software abort command ends the current frame the same way. Bit stuffing, CRC, flags and serial timing belong to the framer.

Top module: `hdlc_txpool`

## Requirements
- R1: After reset out_valid, out_abort, wr_blocked, irq and all status bits are 0.
- R2: Bytes written before a send command leave on out_data in write order. While out_valid is 1 and out_ready is 0, out_valid and out_data hold (unless an abort command arrives).
- R3: For a bank committed with cmd_end=1, its last byte has out_eof=1 and every other byte has out_eof=0. When that byte is accepted, status bit 1 (frame done) is set.
- R4: A bank committed with cmd_end=0 leaves the frame open. The next committed bank continues it with no marker in between, and when an open-frame bank drains, status bit 0 (next block request) is set.
- R5: A send command accepted while the other bank is still queued or transmitting makes wr_blocked=1 until that bank has drained. Writes while blocked are discarded and set status bit 3 (write error).
- R6: Writes beyond 32 bytes into one bank are discarded and set status bit 3. The bank then sends only its first 32 bytes.
- R7: A send command issued with no byte written into the current bank is ignored, with or without cmd_end: no output and no status change.
- R8: If a frame is open, no bank is queued and out_ready=1, the block presents an abort marker (out_valid=1, out_abort=1, out_eof=0) and sets status bit 2 (underrun). It also empties both banks.
- R9: cmd_abort during an open frame yields one abort marker. Both banks are emptied, so no queued byte is sent afterwards, wr_blocked returns to 0, and a new frame then starts cleanly.
- R10: Status bits are sticky and are cleared by writing 1 to the matching bit of irq_clr. irq is the OR of the status bits whose irq_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Processor write byte |
| cmd_send | input | 1 | Send command: commit the accessible bank |
| cmd_end | input | 1 | Qualifier for cmd_send: the bank closes the frame |
| cmd_abort | input | 1 | Software abort command |
| irq_clr | input | 4 | Write-one-to-clear mask for the status bits |
| irq_en | input | 4 | Interrupt enable per status bit |
| out_valid | output | 1 | Stream item valid |
| out_data | output | 8 | Stream byte |
| out_eof | output | 1 | Item is the last byte of a frame |
| out_abort | output | 1 | Item is an abort marker, not data |
| out_ready | input | 1 | Framer accepts the item / wants a byte |
| wr_blocked | output | 1 | Processor bank is locked; writes are discarded |
| status | output | 4 | Sticky flags: 0 request, 1 done, 2 underrun, 3 write error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the framer treats out_ready as a request for a byte. They also assume irq_clr is not pulsed in the same cycle as the event that sets the bit it clears, and that cmd_abort does not coincide with the acceptance of a pending abort marker. The stimulus drives every input on the falling edge. It clears status only in quiet cycles and issues aborts only while out_ready is low. It commits each continuation bank before the preceding one drains, except where an underrun is the intended outcome.

// File: rtl/txp_pkg.sv
package txp_pkg;
   localparam int ST_REQ  = 0;
   localparam int ST_DONE = 1;
   localparam int ST_UND  = 2;
   localparam int ST_WERR = 3;
   localparam int ST_N    = 4;
endpackage

// File: rtl/txp_bank_store.sv
module txp_bank_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              we_bank,
   input  logic [IDX_W-1:0]  we_idx,
   input  logic [DATA_W-1:0] we_data,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_q [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (we_bank == b[0])) mem[we_idx] <= we_data;
      end
      assign bank_q[b] = mem[rd_idx];
   end

   assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/txp_pool_state.sv
module txp_pool_state #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             commit,
   input  logic [CNT_W-1:0] commit_len,
   input  logic             commit_eom,
   input  logic             release_i,
   output logic             cpu_bank,
   output logic             tx_bank,
   output logic             cpu_locked,
   output logic             tx_ready,
   output logic [CNT_W-1:0] tx_len,
   output logic             tx_eom
);
   logic [1:0]       full_q;
   logic [1:0]       eom_q;
   logic [CNT_W-1:0] len_q [2];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         full_q   <= '0;
         eom_q    <= '0;
         cpu_bank <= 1'b0;
         tx_bank  <= 1'b0;
         len_q[0] <= '0;
         len_q[1] <= '0;
      end else begin
         if (commit) begin
            full_q[cpu_bank] <= 1'b1;
            eom_q[cpu_bank]  <= commit_eom;
            len_q[cpu_bank]  <= commit_len;
            cpu_bank         <= ~cpu_bank;
         end
         if (release_i) begin
            full_q[tx_bank] <= 1'b0;
            tx_bank         <= ~tx_bank;
         end
      end
   end

   assign cpu_locked = full_q[cpu_bank];
   assign tx_ready   = full_q[tx_bank];
   assign tx_len     = len_q[tx_bank];
   assign tx_eom     = eom_q[tx_bank];
endmodule

// File: rtl/txp_wr_side.sv
module txp_wr_side #(
   parameter int DEPTH = 32,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic             cmd_send,
   input  logic             cmd_end,
   input  logic             cpu_locked,
   output logic             mem_we,
   output logic [IDX_W-1:0] mem_idx,
   output logic             commit,
   output logic [CNT_W-1:0] commit_len,
   output logic             commit_eom,
   output logic             werr
);
   logic [CNT_W-1:0] cnt_q;
   logic             room;

   assign room       = (cnt_q < CNT_W'(DEPTH));
   assign mem_we     = wr_en && !cpu_locked && room && !flush;
   assign mem_idx    = cnt_q[IDX_W-1:0];
   assign werr       = wr_en && !(cpu_locked == 1'b0 && room);
   assign commit_len = cnt_q + CNT_W'(mem_we);
   assign commit_eom = cmd_end;
   assign commit     = cmd_send && !cpu_locked && !flush && (commit_len != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || flush)  cnt_q <= '0;
      else if (commit)      cnt_q <= '0;
      else if (mem_we)      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/txp_rd_side.sv
module txp_rd_side #(
   parameter int DEPTH = 32,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_ready,
   input  logic [CNT_W-1:0] tx_len,
   input  logic             tx_eom,
   input  logic             out_ready,
   input  logic             sw_abort,
   output logic [IDX_W-1:0] rd_idx,
   output logic             out_valid,
   output logic             out_eof,
   output logic             out_abort,
   output logic             release_o,
   output logic             flush,
   output logic             req_set,
   output logic             done_set,
   output logic             und_set
);
   logic [CNT_W-1:0] cnt_q;
   logic             in_frame_q;
   logic             abort_q;
   logic             last;
   logic             take;
   logic             data_take;
   logic             starve;

   assign last      = (cnt_q == tx_len - 1'b1);
   assign rd_idx    = cnt_q[IDX_W-1:0];
   assign out_abort = abort_q;
   assign out_valid = abort_q || tx_ready;
   assign out_eof   = !abort_q && tx_ready && tx_eom && last;
   assign take      = out_valid && out_ready;
   assign data_take = take && !abort_q && !sw_abort;
   assign starve    = in_frame_q && !tx_ready && !abort_q && out_ready && !sw_abort;
   assign flush     = sw_abort || starve;
   assign release_o = data_take && last;
   assign req_set   = release_o && !tx_eom;
   assign done_set  = release_o && tx_eom;
   assign und_set   = starve;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         abort_q    <= 1'b0;
      end else if (sw_abort) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         abort_q    <= in_frame_q || (abort_q && !take);
      end else if (starve) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         abort_q    <= 1'b1;
      end else if (take && abort_q) begin
         abort_q    <= 1'b0;
      end else if (data_take) begin
         if (last) begin
            cnt_q      <= '0;
            in_frame_q <= !tx_eom;
         end else begin
            cnt_q      <= cnt_q + 1'b1;
            in_frame_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/txp_irq.sv
module txp_irq #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_i) | set_i;
   end
   assign irq = |(stat & en_i);
endmodule

// File: rtl/hdlc_txpool.sv
module hdlc_txpool #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int SN    = txp_pkg::ST_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cmd_send,
   input  logic              cmd_end,
   input  logic              cmd_abort,
   input  logic [SN-1:0]     irq_clr,
   input  logic [SN-1:0]     irq_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_eof,
   output logic              out_abort,
   input  logic              out_ready,
   output logic              wr_blocked,
   output logic [SN-1:0]     status,
   output logic              irq
);
   import txp_pkg::*;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hdlc_txpool: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("hdlc_txpool: DATA_W must be positive");
   end

   logic             cpu_bank, tx_bank, cpu_locked, tx_ready, tx_eom;
   logic [CNT_W-1:0] tx_len, commit_len;
   logic             commit, commit_eom, release_w, flush;
   logic             mem_we, werr, req_set, done_set, und_set;
   logic [IDX_W-1:0] mem_idx, rd_idx;
   logic [SN-1:0]    set_v;

   txp_pool_state #(.CNT_W(CNT_W)) u_state (
      .clk, .rst_n, .flush, .commit, .commit_len, .commit_eom,
      .release_i(release_w), .cpu_bank, .tx_bank, .cpu_locked,
      .tx_ready, .tx_len, .tx_eom
   );

   txp_wr_side #(.DEPTH(DEPTH)) u_wr (
      .clk, .rst_n, .flush, .wr_en, .cmd_send, .cmd_end, .cpu_locked,
      .mem_we, .mem_idx, .commit, .commit_len, .commit_eom, .werr
   );

   txp_bank_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk, .we(mem_we), .we_bank(cpu_bank), .we_idx(mem_idx), .we_data(wr_data),
      .rd_bank(tx_bank), .rd_idx, .rd_data(out_data)
   );

   txp_rd_side #(.DEPTH(DEPTH)) u_rd (
      .clk, .rst_n, .tx_ready, .tx_len, .tx_eom, .out_ready,
      .sw_abort(cmd_abort), .rd_idx, .out_valid, .out_eof, .out_abort,
      .release_o(release_w), .flush, .req_set, .done_set, .und_set
   );

   always_comb begin
      set_v          = '0;
      set_v[ST_REQ]  = req_set;
      set_v[ST_DONE] = done_set;
      set_v[ST_UND]  = und_set;
      set_v[ST_WERR] = werr;
   end

   txp_irq #(.N(SN)) u_irq (
      .clk, .rst_n, .set_i(set_v), .clr_i(irq_clr), .en_i(irq_en),
      .stat(status), .irq
   );

   assign wr_blocked = cpu_locked;
endmodule

// File: rtl/hdlc_txpool_chk.sv
module hdlc_txpool_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              cmd_abort,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_eof,
   input logic              out_abort,
   input logic              out_ready,
   input logic              wr_blocked,
   input logic [3:0]        status
);
   // R2: a presented item stays until taken
   a_r2_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !cmd_abort) |=> out_valid);
   a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !out_abort && !cmd_abort) |=> $stable(out_data));
   // R3: an abort marker never claims to end a frame
   a_r3_eof_not_abort: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_eof && out_abort));
   // R3: frame-done only follows an accepted end-of-frame byte
   a_r3_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> $past(out_valid && out_ready && out_eof));
   // R5: a write into a locked bank is flagged
   a_r5_blocked_write_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_blocked) |=> status[3]);
   // R8: an underrun flag comes with an abort marker on the stream
   a_r8_und_marker: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[2]) |-> (out_valid && out_abort));
endmodule

bind hdlc_txpool hdlc_txpool_chk #(.DATA_W(DATA_W)) u_chk (
   .clk, .rst_n, .wr_en, .cmd_abort, .out_valid, .out_data, .out_eof,
   .out_abort, .out_ready, .wr_blocked, .status
);

// File: tb/tb_hdlc_txpool.sv
`timescale 1ns/1ps
module tb_hdlc_txpool;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       wr_en = 0;
   logic [7:0] wr_data = 0;
   logic       cmd_send = 0, cmd_end = 0, cmd_abort = 0;
   logic [3:0] irq_clr = 0, irq_en = 0;
   logic       out_valid, out_eof, out_abort, out_ready = 0;
   logic [7:0] out_data;
   logic       wr_blocked, irq;
   logic [3:0] status;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // expected item: {abort, eof, data}
   logic [9:0] exp_q [$];

   always #2 clk = ~clk;

   hdlc_txpool dut (
      .clk, .rst_n, .wr_en, .wr_data, .cmd_send, .cmd_end, .cmd_abort,
      .irq_clr, .irq_en, .out_valid, .out_data, .out_eof, .out_abort,
      .out_ready, .wr_blocked, .status, .irq
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: compares every accepted item against the scoreboard
   always begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(0, "R2/R7/R9 unexpected item", {out_abort, out_eof, out_data}, 0);
         end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            if (e[9])
               check(out_abort && !out_eof, "R8/R9 abort marker",
                     {out_abort, out_eof}, 2'b10);
            else
               check({out_abort, out_eof, out_data} == e, "R2/R3/R4 stream item",
                     {out_abort, out_eof, out_data}, e);
         end
      end
   end

   task automatic wr_byte(input logic [7:0] d);
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   // writes n bytes from base, commits, and pushes the expected items
   task automatic send_block(input logic [7:0] base, input int n, input bit eom);
      for (int i = 0; i < n; i++) wr_byte(base + 8'(i));
      cmd_send = 1; cmd_end = eom;
      @(negedge clk);
      cmd_send = 0; cmd_end = 0;
      for (int i = 0; i < n; i++)
         exp_q.push_back({1'b0, (eom && i == n - 1), base + 8'(i)});
   endtask

   task automatic drain();
      for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
   endtask

   task automatic clear_all();
      irq_clr = 4'hF;
      @(negedge clk);
      irq_clr = 0;
   endtask

   initial begin
      #(4 * 20000);
      $display("FAIL watchdog: actual timeout expected completion");
      errors++;
      checks++;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check(!out_valid && !out_abort && !wr_blocked && !irq && status == 0,
            "R1 reset state", {out_valid, out_abort, wr_blocked, irq, status}, 0);
      rst_n = 1;
      @(negedge clk);

      // R2/R3 single closed frame
      out_ready = 1;
      send_block(8'h10, 5, 1);
      drain();
      check(status[1], "R3 frame done flag", status, 4'b0010);
      check(status[0] == 0, "R4 no request on closed block", status, 4'b0010);
      clear_all();
      #1 check(status == 0, "R10 w1c clears status", status, 0);
      @(negedge clk);

      // R7 zero-byte command
      cmd_send = 1; cmd_end = 1;
      @(negedge clk);
      cmd_send = 0; cmd_end = 0;
      repeat (5) @(negedge clk);
      #1 check(!out_valid && status == 0, "R7 empty command ignored",
               {out_valid, status}, 0);
      @(negedge clk);

      // R4/R5 two-bank frame with lockout
      out_ready = 0;
      send_block(8'h00, 32, 0);
      send_block(8'h40, 10, 1);
      #1 check(wr_blocked, "R5 blocked after second command", wr_blocked, 1);
      @(negedge clk);
      wr_byte(8'hEE);
      #1 check(status[3], "R5 write while blocked flagged", status, 4'b1000);
      @(negedge clk);
      out_ready = 1;
      drain();
      check(!wr_blocked, "R5 unblocked after drain", wr_blocked, 0);
      check(status == 4'b1011, "R4 request and done flags", status, 4'b1011);
      clear_all();

      // R6 overflow of one bank
      out_ready = 0;
      for (int i = 0; i < 33; i++) wr_byte(8'(8'h80 + i));
      #1 check(status[3], "R6 overflow write flagged", status, 4'b1000);
      @(negedge clk);
      cmd_send = 1; cmd_end = 1;
      @(negedge clk);
      cmd_send = 0; cmd_end = 0;
      for (int i = 0; i < 32; i++)
         exp_q.push_back({1'b0, (i == 31), 8'(8'h80 + i)});
      out_ready = 1;
      drain();
      clear_all();

      // R8/R10 underrun with interrupt mask
      irq_en = 4'b0100;
      out_ready = 1;
      send_block(8'h20, 3, 0);
      exp_q.push_back(10'h200);
      drain();
      check(status[2] && status[0], "R8 underrun and request flags", status, 4'b0101);
      check(irq, "R10 enabled underrun drives irq", irq, 1);
      irq_clr = 4'b0100;
      @(negedge clk);
      irq_clr = 0;
      #1 check(!irq && status == 4'b0001, "R10 irq drops after clear",
               {irq, status}, 4'b0001);
      @(negedge clk);
      clear_all();

      // R9 software abort mid-frame
      out_ready = 0;
      send_block(8'hA0, 4, 0);
      exp_q.delete();
      exp_q.push_back({2'b00, 8'hA0});
      send_block(8'hB0, 2, 1);
      exp_q.pop_back(); exp_q.pop_back();
      @(negedge clk);
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
      cmd_abort = 1;
      @(negedge clk);
      cmd_abort = 0;
      exp_q.push_back(10'h200);
      #1 check(!wr_blocked, "R9 banks emptied by abort", wr_blocked, 0);
      @(negedge clk);
      out_ready = 1;
      repeat (10) @(negedge clk);
      #1 check(exp_q.size() == 0 && !out_valid, "R9 no queued byte after abort",
               {exp_q.size(), out_valid}, 0);
      check(status[2] == 0, "R9 abort is not an underrun", status, 0);
      @(negedge clk);
      send_block(8'hC0, 2, 1);
      drain();
      check(status[1], "R9 new frame after abort completes", status, 4'b0010);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule